// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a cycle-based, synthesizable model of a byte-wide memory that can be written only once, in the sense that programming clears bits and never sets them. It is meant to sit on the far side of a device programmer under test. On every rising clock edge it decodes the active-low select, output-gate and program-strobe inputs, together with two level flags. One flag stands for the raised programming supply. The other stands for the high-voltage condition on the identifier address line. From these it picks one operating mode and holds that mode in a state register. The registered mode and the byte captured with it drive the data bus and its drive-enable one cycle after the inputs were presented.

The modes are held in the enumerated state `otp_mode_e`:

- `MODE_STANDBY` (deselected).
- `MODE_INHIBIT` (deselected while the supply is raised).
- `MODE_DISABLE` (selected, outputs gated off).
- `MODE_READ` (array read).
- `MODE_PROGRAM` (AND-write of the data input).
- `MODE_VERIFY` (read-back while the supply is raised).
- `MODE_IDREAD` (fixed identifier bytes).

Every edge moves the state register to whichever mode the current inputs decode to. Any mode can follow any other, and reset forces `MODE_STANDBY`.

The array depth is a parameter and must be a power of two. Only the low log2(DEPTH) address bits pick a byte, and the upper address bits alias. Reset models a fresh part by filling the array with ones.

Top module: `otp_byte_store`

## Requirements
- R1: While `rst_n` is low, and after it is released, every byte reads FFh. During reset `dout_en` is 0 and `dout` is 00h.
- R2: `cs_n`=0, `oe_n`=0 and `vprog`=0, with no identifier condition, drive the byte at `addr[log2(DEPTH)-1:0]` on `dout` with `dout_en`=1 one cycle later. `prog_n` has no effect here, and the upper address bits alias.
- R3: `cs_n`=1 makes `dout_en`=0 and `dout`=00h one cycle later, whatever `oe_n` is.
- R4: `cs_n`=0 and `oe_n`=1 with `vprog`=0 float the outputs one cycle later, and no byte is written even if `prog_n`=0.
- R5: `vprog`=1, `cs_n`=0, `oe_n`=1 and `prog_n`=0 at a rising edge write `din` into the addressed byte, and the outputs float one cycle later.
- R6: A write stores the bitwise AND of the old byte and `din`, so a bit at 0 stays 0.
- R7: `vprog`=1, `cs_n`=0, `oe_n`=0 and `prog_n`=1 drive the stored byte with `dout_en`=1 one cycle later (verify).
- R8: `vprog`=1 with `cs_n`=1 writes nothing and floats the outputs (inhibit).
- R9: `id_hv`=1, `vprog`=0, `cs_n`=0, `oe_n`=0 and `addr[17:1]`=0 return C2h when `addr[0]`=0 and 20h when `addr[0]`=1. This takes priority over the array content.
- R10: Both identifier bytes have odd parity over all 8 bits, with bit 7 acting as the parity bit.
- R11: With `id_hv`=1 but some bit of `addr[17:1]` set, an ordinary array read takes place.
- R12: `vprog`=1, `cs_n`=0 with both `oe_n`=0 and `prog_n`=0 writes nothing and floats the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, fills the array with ones |
| cs_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe |
| vprog | input | 1 | Programming supply present |
| id_hv | input | 1 | High voltage present on the identifier address line |
| addr | input | 18 | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Data bus, 00h when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The bench programs a byte twice with overlapping patterns. A model that overwrote instead of ANDing would read back the second pattern, not the AND of both. It then tries the write-like combinations that must not write: inhibit, strobe with the gate also low, and strobe without the supply. It reads each target afterwards, so any stray write appears as a byte other than FFh. The identifier bytes are requested both over a programmed location and with a stray upper address bit set. This exposes a decoder that gives the array priority or ignores the upper bits. A final mid-run reset shows whether the array really returns to all ones.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_INHIBIT,
        MODE_DISABLE,
        MODE_READ,
        MODE_PROGRAM,
        MODE_VERIFY,
        MODE_IDREAD
    } otp_mode_e;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      cs_n,
    input  logic      oe_n,
    input  logic      prog_n,
    input  logic      vprog,
    input  logic      id_hv,
    input  logic      id_addr_ok,
    output otp_mode_e mode
);
    always_comb begin
        if (cs_n) begin
            mode = vprog ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vprog) begin
            if (!prog_n && oe_n)
                mode = MODE_PROGRAM;
            else if (prog_n && !oe_n)
                mode = MODE_VERIFY;
            else
                mode = MODE_DISABLE;
        end else if (oe_n) begin
            mode = MODE_DISABLE;
        end else if (id_hv && id_addr_ok) begin
            mode = MODE_IDREAD;
        end else begin
            mode = MODE_READ;
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '1;
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
    parameter logic [6:0] MFR_LOW = 7'h42,
    parameter logic [6:0] DEV_LOW = 7'h20
) (
    input  logic       sel,
    output logic [7:0] id_byte
);
    localparam logic [6:0] LOWS [2] = '{MFR_LOW, DEV_LOW};
    logic [7:0] table_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_code
        assign table_q[g] = {~^LOWS[g], LOWS[g]};
    end

    assign id_byte = table_q[sel];
endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              vprog,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    otp_mode_e         mode_d, mode_q;
    logic [DATA_W-1:0] arr_rdata, id_byte, data_q;
    logic              id_addr_ok;

    assign id_addr_ok = (addr[ADDR_W-1:1] == '0);

    otp_mode_decode u_decode (
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .prog_n    (prog_n),
        .vprog     (vprog),
        .id_hv     (id_hv),
        .id_addr_ok(id_addr_ok),
        .mode      (mode_d)
    );

    otp_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(mode_d == MODE_PROGRAM),
        .idx  (addr[IDX_W-1:0]),
        .wdata(din),
        .rdata(arr_rdata)
    );

    otp_id_rom u_id (
        .sel    (addr[0]),
        .id_byte(id_byte)
    );

    // State register: the mode decoded at each edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STANDBY;
            data_q <= '0;
        end else begin
            mode_q <= mode_d;
            data_q <= (mode_d == MODE_IDREAD) ? id_byte : arr_rdata;
        end
    end

    // Outputs from the registered mode.
    always_comb begin
        unique case (mode_q)
            MODE_READ, MODE_VERIFY, MODE_IDREAD: begin
                dout_en = 1'b1;
                dout    = data_q;
            end
            MODE_STANDBY, MODE_INHIBIT, MODE_DISABLE, MODE_PROGRAM: begin
                dout_en = 1'b0;
                dout    = '0;
            end
            default: begin
                dout_en = 1'b0;
                dout    = '0;
            end
        endcase
    end
endmodule

// File: rtl/otp_byte_store_sva.sv
module otp_byte_store_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        oe_n,
    input logic        prog_n,
    input logic        vprog,
    input logic        id_hv,
    input logic [16:0] addr_hi,
    input logic [7:0]  dout,
    input logic        dout_en
);
    AST_STANDBY_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_en && dout == 8'h00)); // R3

    AST_GATE_HIGH_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && oe_n) |=> !dout_en); // R4

    AST_PROGRAM_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (vprog && !cs_n && oe_n && !prog_n) |=> !dout_en); // R5

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && !vprog) |=> dout_en); // R2

    AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (vprog && !cs_n && !oe_n && prog_n) |=> dout_en); // R7

    AST_BOTH_LOW_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (vprog && !cs_n && !oe_n && !prog_n) |=> !dout_en); // R12

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && !vprog && id_hv && addr_hi == 17'h0) |=> (^dout == 1'b1)); // R10
endmodule

bind otp_byte_store otp_byte_store_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .prog_n (prog_n),
    .vprog  (vprog),
    .id_hv  (id_hv),
    .addr_hi(addr[17:1]),
    .dout   (dout),
    .dout_en(dout_en)
);

// File: tb/tb_otp_byte_store.sv
module tb_otp_byte_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1, vprog = 1'b0, id_hv = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    otp_byte_store dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .prog_n(prog_n),
        .vprog(vprog), .id_hv(id_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    // {cs_n,oe_n,prog_n,vprog,id_hv}, addr, din, expected enable, expected byte
    localparam int NV = 19;
    localparam logic [39:0] VEC [NV] = '{
        {5'b00100, 18'h00005, 8'h00, 1'b1, 8'hFF}, // read fresh byte
        {5'b01010, 18'h00005, 8'hA5, 1'b0, 8'h00}, // program A5
        {5'b00110, 18'h00005, 8'h00, 1'b1, 8'hA5}, // verify
        {5'b01010, 18'h00005, 8'hF0, 1'b0, 8'h00}, // program F0 over A5
        {5'b00100, 18'h00005, 8'h00, 1'b1, 8'hA0}, // read AND result
        {5'b11010, 18'h00006, 8'h00, 1'b0, 8'h00}, // inhibit
        {5'b00100, 18'h00006, 8'h00, 1'b1, 8'hFF}, // untouched
        {5'b10100, 18'h00005, 8'h00, 1'b0, 8'h00}, // standby, gate low
        {5'b01000, 18'h00006, 8'h00, 1'b0, 8'h00}, // disable, strobe low
        {5'b00100, 18'h00006, 8'h00, 1'b1, 8'hFF}, // untouched
        {5'b00010, 18'h00007, 8'h00, 1'b0, 8'h00}, // gate and strobe low
        {5'b00100, 18'h00007, 8'h00, 1'b1, 8'hFF}, // untouched
        {5'b01010, 18'h00001, 8'h00, 1'b0, 8'h00}, // program byte 1 to 00
        {5'b00101, 18'h00000, 8'h00, 1'b1, 8'hC2}, // maker id
        {5'b00101, 18'h00001, 8'h00, 1'b1, 8'h20}, // device id over 00
        {5'b00101, 18'h00005, 8'h00, 1'b1, 8'hA0}, // hv with bit 2 set
        {5'b00101, 18'h20001, 8'h00, 1'b1, 8'h00}, // hv with bit 17 set
        {5'b00100, 18'h00105, 8'h00, 1'b1, 8'hA0}, // alias of byte 5
        {5'b00000, 18'h00000, 8'h00, 1'b1, 8'hFF}  // read, strobe low
    };
    localparam string TAG [NV] = '{
        "R1", "R5", "R7", "R6", "R6", "R8", "R8", "R3", "R4", "R4",
        "R12", "R12", "R5", "R9", "R9", "R11", "R11", "R2", "R2"
    };

    task automatic check(input string req, input logic exp_en, input logic [7:0] exp_d);
        n_chk++;
        if (dout_en !== exp_en || dout !== exp_d) begin
            n_fail++;
            $display("FAIL %s: got en=%0b dout=%02h, expected en=%0b dout=%02h",
                     req, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic drive(input logic [4:0] ctl, input logic [17:0] a, input logic [7:0] d);
        {cs_n, oe_n, prog_n, vprog, id_hv} = ctl;
        addr = a;
        din  = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][39:35], VEC[i][34:17], VEC[i][16:9]);
            @(negedge clk);
            check(TAG[i], VEC[i][8], VEC[i][7:0]);
        end
        // R10: odd parity of both identifier bytes
        for (int b = 0; b < 2; b++) begin
            drive(5'b00101, 18'(b), 8'h00);
            @(negedge clk);
            n_chk++;
            if (^dout !== 1'b1) begin
                n_fail++;
                $display("FAIL R10: got parity %0b of %02h, expected 1", ^dout, dout);
            end
        end
        // R3: standby with gate high as well
        drive(5'b11100, 18'h00005, 8'h00);
        @(negedge clk);
        check("R3", 1'b0, 8'h00);
        // R1: mid-run reset restores all ones
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 8'h00);
        rst_n = 1'b1;
        drive(5'b00100, 18'h00005, 8'h00);
        @(negedge clk);
        check("R1", 1'b1, 8'hFF);
        drive(5'b00100, 18'h00001, 8'h00);
        @(negedge clk);
        check("R1", 1'b1, 8'hFF);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule